// File: doc/BRIEF.md
# Radix-4 Digit Partial-Product Signed Multiplier

This block multiplies a W-bit two's-complement word by an L-bit two's-complement sample and returns the exact W+L-bit product. The sample is cut into L/2 two-bit digits. Each digit goes through a one-hot decoder, and the decoder drives an AND/OR selection cell. The cell gates one of a small set of precomputed multiples of the word.

The lower digits are unsigned and choose among w, 2w and 3w. The 3w term is formed by one adder and shared by every digit. The topmost digit carries the sign of the sample, so its cell is offered w, -2w and -w instead. The L/2 digit partial products are summed by a balanced shift-add tree in which digit k has weight 4^k.

The per-digit partial products also leave the block on their own port, so that neighbouring logic can reuse the generator without repeating it. Operands enter through a valid/ready handshake. When the OUT_REG parameter is 1, a register stage holds the product and applies back-pressure: a held result is never lost or overwritten. When OUT_REG is 0, the stage is a wire: out_valid follows in_valid and in_ready follows out_ready.

The sample width L must be a power of two of at least 4, so that the digit count L/2 is also a power of two.

Top module: `dmul_top`

## Requirements
- R1: Digit k is taken from sample bits [2k+1:2k]. Its partial product is placed on digit_pp bits [k*(W+2) +: W+2], and it follows the current in_word and in_sample combinationally.
- R2: For every digit except the top one, the partial product is the W+2-bit two's-complement value 0, w, 2w or 3w for digit value 0, 1, 2 or 3.
- R3: The top digit is signed, so that codes 0, 1, 2 and 3 stand for 0, 1, -2 and -1. Its partial product is 0, w, -2w or -w respectively.
- R4: out_product equals the signed product of in_word and in_sample in W+L bits for every operand pair, including both most negative values.
- R5: With OUT_REG=1, a pair accepted at a clock edge (in_valid and in_ready high) appears on out_product with out_valid high right after that edge.
- R6: With OUT_REG=1, while out_valid is high and out_ready is low, out_valid and out_product keep their values and in_ready is low, whatever the inputs do.
- R7: With OUT_REG=1, in_ready is high whenever the output stage is empty or out_ready is high.
- R8: While rst_n is low, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take the operand pair |
| in_word | input | W | Two's-complement multiplicand |
| in_sample | input | L | Two's-complement multiplier, split into digits |
| out_valid | output | 1 | out_product holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_product | output | W+L | Signed full-precision product |
| digit_pp | output | (L/2)*(W+2) | Per-digit partial products, lane k for digit k |

## Verification
The main function is tried on every one of the 65536 pairs of 8-bit operands. This covers both most negative values, where an error in the -2w multiple or in the width of a multiple would surface, and top-digit codes 2 and 3, which tell a signed top digit from one treated as unsigned. Each digit lane is compared on the same sweep, which separates a wrong decode (for example, 2w and 3w swapped) from an error in the sum tree. A separate stall case holds the output while the operands change underneath. This tells a register that holds its result from one that reloads it, and it checks that in_ready drops only while the output is full and blocked.

// File: rtl/dmul_pkg.sv
package dmul_pkg;
  // width of one gated multiple: word plus two guard bits for 3w and -2w
  function automatic int pp_width(input int w);
    return w + 2;
  endfunction

  // width of the full signed product
  function automatic int prod_width(input int w, input int l);
    return w + l;
  endfunction

  // number of two-bit digits in the sample
  function automatic int digit_count(input int l);
    return l / 2;
  endfunction
endpackage

// File: rtl/dmul_digit_dec.sv
module dmul_digit_dec (
  input  logic [1:0] digit,
  output logic [2:0] hot
);
  // hot[0] for code 1, hot[1] for code 2, hot[2] for code 3, none for 0
  always_comb begin
    hot[0] = digit[0] & ~digit[1];
    hot[1] = ~digit[0] & digit[1];
    hot[2] = digit[0] & digit[1];
  end
endmodule

// File: rtl/dmul_sel_cell.sv
module dmul_sel_cell #(
  parameter int PW = 10
) (
  input  logic [2:0]    hot,
  input  logic [PW-1:0] m_a,
  input  logic [PW-1:0] m_b,
  input  logic [PW-1:0] m_c,
  output logic [PW-1:0] pp
);
  logic [PW-1:0] g_a, g_b, g_c;

  // gate each candidate with its decode bit, then merge bitwise
  always_comb begin
    g_a = m_a & {PW{hot[0]}};
    g_b = m_b & {PW{hot[1]}};
    g_c = m_c & {PW{hot[2]}};
    pp  = g_a | g_b | g_c;
  end
endmodule

// File: rtl/dmul_ppgen.sv
module dmul_ppgen #(
  parameter int W = 8,
  parameter int L = 8
) (
  input  logic [W-1:0]                                  word,
  input  logic [L-1:0]                                  sample,
  output logic [dmul_pkg::digit_count(L)*dmul_pkg::pp_width(W)-1:0] pp_flat
);
  localparam int ND = dmul_pkg::digit_count(L);
  localparam int PW = dmul_pkg::pp_width(W);

  logic [PW-1:0] m_one, m_two, m_three, m_neg_one, m_neg_two;

  // shared multiples, formed once for all digits
  always_comb begin
    m_one     = {{2{word[W-1]}}, word};
    m_two     = {m_one[PW-2:0], 1'b0};
    m_three   = m_one + m_two;
    m_neg_one = '0 - m_one;
    m_neg_two = '0 - m_two;
  end

  for (genvar k = 0; k < ND; k++) begin : g_dig
    logic [2:0]    hot;
    logic [PW-1:0] ma, mb, mc;

    dmul_digit_dec u_dec (
      .digit (sample[2*k +: 2]),
      .hot   (hot)
    );

    if (k == ND - 1) begin : g_top
      // signed top digit: codes 1, 2, 3 mean +1, -2, -1
      assign ma = m_one;
      assign mb = m_neg_two;
      assign mc = m_neg_one;
    end else begin : g_low
      assign ma = m_one;
      assign mb = m_two;
      assign mc = m_three;
    end

    dmul_sel_cell #(.PW(PW)) u_sel (
      .hot (hot),
      .m_a (ma),
      .m_b (mb),
      .m_c (mc),
      .pp  (pp_flat[k*PW +: PW])
    );
  end
endmodule

// File: rtl/dmul_sum_tree.sv
module dmul_sum_tree #(
  parameter int W = 8,
  parameter int L = 8
) (
  input  logic [dmul_pkg::digit_count(L)*dmul_pkg::pp_width(W)-1:0] pp_flat,
  output logic [dmul_pkg::prod_width(W, L)-1:0]                     sum
);
  localparam int ND = dmul_pkg::digit_count(L);
  localparam int PW = dmul_pkg::pp_width(W);
  localparam int PR = dmul_pkg::prod_width(W, L);
  localparam int NN = 2 * ND - 1;

  // heap layout: leaves at ND-1 .. 2ND-2, root at 0
  logic [PR-1:0] node [NN];

  for (genvar k = 0; k < ND; k++) begin : g_leaf
    logic [PW-1:0] lane;
    assign lane = pp_flat[k*PW +: PW];
    // sign-extend and place at weight 4^k
    assign node[ND-1+k] = {{(PR-PW){lane[PW-1]}}, lane} << (2 * k);
  end

  for (genvar i = 0; i < ND - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign sum = node[0];
endmodule

// File: rtl/dmul_out_stage.sv
module dmul_out_stage #(
  parameter int DW      = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_valid,
  output logic          i_ready,
  input  logic [DW-1:0] i_data,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [DW-1:0] o_data
);
  if (OUT_REG) begin : g_reg
    logic          full_q;
    logic [DW-1:0] data_q;
    logic          take;

    assign i_ready = !full_q || o_ready;
    assign take    = i_valid && i_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        data_q <= '0;
      end else if (take) begin
        full_q <= 1'b1;
        data_q <= i_data;
      end else if (o_ready) begin
        full_q <= 1'b0;
      end
    end

    assign o_valid = full_q;
    assign o_data  = data_q;
  end else begin : g_wire
    assign i_ready = o_ready;
    assign o_valid = i_valid;
    assign o_data  = i_data;
  end
endmodule

// File: rtl/dmul_top.sv
module dmul_top #(
  parameter int W       = 8,
  parameter int L       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                                                      clk,
  input  logic                                                      rst_n,
  input  logic                                                      in_valid,
  output logic                                                      in_ready,
  input  logic [W-1:0]                                              in_word,
  input  logic [L-1:0]                                              in_sample,
  output logic                                                      out_valid,
  input  logic                                                      out_ready,
  output logic [dmul_pkg::prod_width(W, L)-1:0]                     out_product,
  output logic [dmul_pkg::digit_count(L)*dmul_pkg::pp_width(W)-1:0] digit_pp
);
  localparam int PR = dmul_pkg::prod_width(W, L);

  logic [PR-1:0] sum;

  dmul_ppgen #(.W(W), .L(L)) u_ppgen (
    .word    (in_word),
    .sample  (in_sample),
    .pp_flat (digit_pp)
  );

  dmul_sum_tree #(.W(W), .L(L)) u_tree (
    .pp_flat (digit_pp),
    .sum     (sum)
  );

  dmul_out_stage #(.DW(PR), .OUT_REG(OUT_REG)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_valid (in_valid),
    .i_ready (in_ready),
    .i_data  (sum),
    .o_valid (out_valid),
    .o_ready (out_ready),
    .o_data  (out_product)
  );
endmodule

// File: rtl/dmul_top_chk.sv
module dmul_top_chk #(
  parameter int W       = 8,
  parameter int L       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic                                                      clk,
  input logic                                                      rst_n,
  input logic                                                      in_valid,
  input logic                                                      in_ready,
  input logic [W-1:0]                                              in_word,
  input logic [L-1:0]                                              in_sample,
  input logic                                                      out_valid,
  input logic                                                      out_ready,
  input logic [dmul_pkg::prod_width(W, L)-1:0]                     out_product,
  input logic [dmul_pkg::digit_count(L)*dmul_pkg::pp_width(W)-1:0] digit_pp
);
  localparam int ND = dmul_pkg::digit_count(L);
  localparam int PW = dmul_pkg::pp_width(W);
  localparam int PR = dmul_pkg::prod_width(W, L);

  logic signed [PR-1:0] ref_prod;
  logic signed [PW-1:0] word_x;
  assign ref_prod = $signed(in_word) * $signed(in_sample);
  assign word_x   = $signed(in_word);

  // R2
  lane0_triple_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sample[1:0] == 2'd3) |-> (digit_pp[PW-1:0] == PW'(word_x * 3)));

  // R3
  top_minus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sample[L-1:L-2] == 2'd3) |-> (digit_pp[(ND-1)*PW +: PW] == PW'(-word_x)));

  // R3
  top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sample[L-1:L-2] == 2'd0) |-> (digit_pp[(ND-1)*PW +: PW] == '0));

  if (OUT_REG) begin : g_reg
    // R4 R5
    product_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_product == $past(ref_prod)));

    // R6
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_product)));

    // R6
    no_take_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

    // R7
    ready_when_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid || out_ready) |-> in_ready);
  end else begin : g_wire
    // R4
    product_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (out_product == ref_prod && out_valid == in_valid && in_ready == out_ready));
  end
endmodule

bind dmul_top dmul_top_chk #(.W(W), .L(L), .OUT_REG(OUT_REG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_word     (in_word),
  .in_sample   (in_sample),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_product (out_product),
  .digit_pp    (digit_pp)
);

// File: tb/sim_dmul_top.sv
module sim_dmul_top;
  localparam int W  = 8;
  localparam int L  = 8;
  localparam int ND = L / 2;
  localparam int PW = W + 2;
  localparam int PR = W + L;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst_n;
  logic                 in_valid, in_ready;
  logic [W-1:0]         in_word;
  logic [L-1:0]         in_sample;
  logic                 out_valid, out_ready;
  logic [PR-1:0]        out_product;
  logic [ND*PW-1:0]     digit_pp;

  int checks   = 0;
  int failures = 0;

  dmul_top #(.W(W), .L(L), .OUT_REG(1'b1)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_word     (in_word),
    .in_sample   (in_sample),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_product (out_product),
    .digit_pp    (digit_pp)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint prod_of(input int a, input int b);
    return longint'(a) * longint'(b);
  endfunction

  function automatic logic [PW-1:0] lane_exp(input int a, input int b, input int k);
    int d;
    d = (b >> (2 * k)) & 3;
    if (k == ND - 1 && d >= 2) d = d - 4;
    return PW'(d * a);
  endfunction

  task automatic check_product(input int a, input int b);
    check(out_valid == 1'b1, "R5 out_valid", longint'(out_valid), 1);
    check(longint'($signed(out_product)) == prod_of(a, b), "R4 product",
          longint'($signed(out_product)), prod_of(a, b));
  endtask

  task automatic check_lanes(input int a, input int b);
    int bad;
    logic [PW-1:0] got, exp;
    bad = -1;
    got = '0;
    exp = '0;
    for (int k = 0; k < ND; k++) begin
      if (digit_pp[k*PW +: PW] != lane_exp(a, b, k) && bad < 0) begin
        bad = k;
        got = digit_pp[k*PW +: PW];
        exp = lane_exp(a, b, k);
      end
    end
    if (bad == ND - 1)
      check(1'b0, "R1 R3 top lane", longint'($signed(got)), longint'($signed(exp)));
    else if (bad >= 0)
      check(1'b0, "R1 R2 low lane", longint'($signed(got)), longint'($signed(exp)));
    else
      check(1'b1, "R1 R2 R3 lanes", 0, 0);
  endtask

  initial begin
    #(150000 * 10);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int pa, pb;
    bit have_prev;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    out_ready = 1'b1;
    in_word   = '0;
    in_sample = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check(out_valid == 1'b0, "R8 out_valid", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R8 in_ready", longint'(in_ready), 1);
    rst_n = 1'b1;

    // exhaustive sweep, one pair per cycle, no stalls
    have_prev = 1'b0;
    pa = 0;
    pb = 0;
    for (int a = -(1 << (W-1)); a < (1 << (W-1)); a++) begin
      for (int b = -(1 << (L-1)); b < (1 << (L-1)); b++) begin
        @(negedge clk);
        if (have_prev) check_product(pa, pb);
        in_word   = W'(a);
        in_sample = L'(b);
        in_valid  = 1'b1;
        #1;
        check_lanes(a, b);
        pa = a;
        pb = b;
        have_prev = 1'b1;
      end
    end
    @(negedge clk);
    check_product(pa, pb);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R5 drained", longint'(out_valid), 0);

    // stall: accept pair A, block the output, offer pair B
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_word   = W'(-128);
    in_sample = L'(-128);
    #1;
    check(in_ready == 1'b1, "R7 empty ready", longint'(in_ready), 1);
    @(negedge clk);
    check_product(-128, -128);
    check(in_ready == 1'b0, "R6 in_ready low", longint'(in_ready), 0);
    in_word   = W'(37);
    in_sample = L'(-3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R6 valid held", longint'(out_valid), 1);
      check(longint'($signed(out_product)) == prod_of(-128, -128), "R6 product held",
            longint'($signed(out_product)), prod_of(-128, -128));
      check(in_ready == 1'b0, "R6 in_ready low", longint'(in_ready), 0);
    end
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R7 drain ready", longint'(in_ready), 1);
    @(negedge clk);
    check_product(37, -3);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R5 empty after drain", longint'(out_valid), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule